// File: doc/BRIEF.md
# Trace Immediate Reassociation Unit

This block runs as one step of the fill path of a trace cache. It is handed a buffered trace segment of up to sixteen decoded instruction records and looks for pairs of add-immediate instructions where the later one takes its first operand from the earlier one. When such a pair spans two different basic blocks of the segment, the later instruction is rewritten to read the earlier instruction's own source and to carry the sum of both immediates. The dependency on the earlier instruction is removed, so the chain of dependent operations becomes shorter.

Each record holds an operation class, a destination register, two source operands and a 16-bit immediate. Each source operand has a flag saying whether its value is produced inside the segment; when it is, the field holds the index of the producing slot instead of a register number. Each record also carries a 2-bit basic-block number. A one-cycle start pulse captures the whole segment. The unit then visits one slot per cycle in program order. Every slot sees the already rewritten versions of the slots before it, so longer chains fold step by step. When the pass ends, the rewritten segment and a count of folds stay on the outputs until the next start.

Top module: `trace_reassoc_unit`

## Requirements
- R1: One cycle after reset is released, `busy`, `done` and `fold_count` are 0 and every output record field is 0.
- R2: A `start` sampled high while `busy` is low captures the input segment and raises `busy`. `done` is 0 during the pass and becomes 1 exactly N_SLOTS clock edges after the capturing edge, when `busy` drops. `busy` and `done` are never both high.
- R3: Slot i is folded when all of the following hold: its class is add-immediate (class code 1); its operand A is internal (flag 1) with producer index p < i; the record at p has class code 1; and the block numbers of the two slots differ. The fold sets slot i's operand-A flag and field to those of slot p and sets its immediate to the 16-bit sum of both immediates. If slot p's operand A is live-in, the result is live-in on the same register; if it is internal, slot i inherits that producer index.
- R4: A pair whose two block numbers are equal is left unchanged.
- R5: A pair whose immediates, read as signed 16-bit values, sum to a value outside -32768..32767 is left unchanged.
- R6: A slot is left unchanged when any of the following holds: it is not add-immediate; its producer is not add-immediate; its operand A is live-in (flag 0); or its producer index is not below its own index.
- R7: Slots are handled in increasing index order, and each slot uses the already rewritten record of its producer. A cross-block chain of three or more add-immediates therefore resolves to the chain's first source, with the sum of all the immediates.
- R8: The class, destination, block number and the whole of operand B (flag and field) are copied unchanged from input to output for every slot.
- R9: `fold_count` equals the number of slots rewritten in the last pass.
- R10: After `done`, the output records and `fold_count` stay fixed until the next accepted start, even when the inputs change. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the segment and begin a pass |
| in_cls | input | 2*N_SLOTS | Per-slot class: 0 other, 1 add-immediate, 2 branch, 3 ALU |
| in_dst | input | 5*N_SLOTS | Per-slot destination register |
| in_srca_int | input | N_SLOTS | Operand A produced inside the segment |
| in_srca | input | 5*N_SLOTS | Operand A register or producer index |
| in_srcb_int | input | N_SLOTS | Operand B produced inside the segment |
| in_srcb | input | 5*N_SLOTS | Operand B register or producer index |
| in_imm | input | 16*N_SLOTS | Per-slot signed immediate |
| in_blk | input | 2*N_SLOTS | Per-slot basic-block number |
| out_cls | output | 2*N_SLOTS | Rewritten segment: class |
| out_dst | output | 5*N_SLOTS | Rewritten segment: destination |
| out_srca_int | output | N_SLOTS | Rewritten segment: operand A flag |
| out_srca | output | 5*N_SLOTS | Rewritten segment: operand A field |
| out_srcb_int | output | N_SLOTS | Rewritten segment: operand B flag |
| out_srcb | output | 5*N_SLOTS | Rewritten segment: operand B field |
| out_imm | output | 16*N_SLOTS | Rewritten segment: immediate |
| out_blk | output | 2*N_SLOTS | Rewritten segment: block number |
| fold_count | output | $clog2(N_SLOTS+1) | Number of folds in the last pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass finished, results valid |

## Verification
The start pulse is sampled on one rising edge. From the falling edge after it, `busy` must read 1. `done` must still read 0 at the falling edge N_SLOTS-1 cycles later, and must read 1 at the falling edge after that. Only at that point does the bench compare the rewritten records and the fold count with its own program-order model. To cover R10, the bench sends a second start part-way through a pass together with new inputs; `done` must still rise on the original cycle, with results taken from the first segment. It then scrambles the inputs after `done` and compares the outputs again several cycles later.

// File: rtl/trace_reassoc_pkg.sv
package trace_reassoc_pkg;

    localparam int REG_W     = 5;
    localparam int IMM_W     = 16;
    localparam int BLK_W     = 2;
    localparam int MAX_SLOTS = 16;

    typedef enum logic [1:0] {
        CLS_OTHER  = 2'd0,
        CLS_ADDI   = 2'd1,
        CLS_BRANCH = 2'd2,
        CLS_ALU    = 2'd3
    } op_cls_e;

    typedef struct packed {
        op_cls_e            cls;
        logic [REG_W-1:0]   dst;
        logic               srca_int;
        logic [REG_W-1:0]   srca;
        logic               srcb_int;
        logic [REG_W-1:0]   srcb;
        logic [IMM_W-1:0]   imm;
        logic [BLK_W-1:0]   blk;
    } slot_t;

    // Fields of a record that a later consumer may need
    typedef struct packed {
        op_cls_e            cls;
        logic               srca_int;
        logic [REG_W-1:0]   srca;
        logic [IMM_W-1:0]   imm;
        logic [BLK_W-1:0]   blk;
    } prod_view_t;

    // Returns {signed_overflow, sum}
    function automatic logic [IMM_W:0] imm_add_chk(input logic [IMM_W-1:0] a,
                                                   input logic [IMM_W-1:0] b);
        logic [IMM_W-1:0] s;
        logic             ovf;
        s   = a + b;
        ovf = (a[IMM_W-1] == b[IMM_W-1]) && (s[IMM_W-1] != a[IMM_W-1]);
        return {ovf, s};
    endfunction

endpackage

// File: rtl/reassoc_pass_ctrl.sv
module reassoc_pass_ctrl #(
    parameter int N_SLOTS = 16,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             load,
    output logic             step,
    output logic [IDX_W-1:0] cursor,
    output logic             busy,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SLOTS - 1);

    assign load = start && !busy;
    assign step = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cursor <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            done   <= 1'b0;
            cursor <= '0;
        end else if (busy) begin
            if (cursor == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                cursor <= cursor + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/reassoc_slot_pick.sv
module reassoc_slot_pick
    import trace_reassoc_pkg::*;
#(
    parameter int N_SLOTS = 16,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  slot_t            seg   [N_SLOTS],
    input  prod_view_t       views [N_SLOTS],
    input  logic [IDX_W-1:0] cursor,
    output slot_t            cur,
    output prod_view_t       prod,
    output logic             prod_ok
);
    always_comb begin
        cur     = seg[cursor];
        // Producer must lie strictly earlier in program order
        prod_ok = cur.srca < REG_W'(cursor);
        prod    = views[cur.srca[IDX_W-1:0]];
    end
endmodule

// File: rtl/reassoc_fold.sv
module reassoc_fold
    import trace_reassoc_pkg::*;
(
    input  slot_t      cur,
    input  prod_view_t prod,
    input  logic       prod_ok,
    output slot_t      nxt,
    output logic       fold
);
    logic [IMM_W:0] chk;

    always_comb begin
        chk  = imm_add_chk(prod.imm, cur.imm);
        nxt  = cur;
        fold = 1'b0;
        if (cur.cls == CLS_ADDI && cur.srca_int && prod_ok &&
            prod.cls == CLS_ADDI && prod.blk != cur.blk && !chk[IMM_W]) begin
            fold         = 1'b1;
            nxt.srca_int = prod.srca_int;
            nxt.srca     = prod.srca;
            nxt.imm      = chk[IMM_W-1:0];
        end
    end
endmodule

// File: rtl/trace_reassoc_unit.sv
module trace_reassoc_unit
    import trace_reassoc_pkg::*;
#(
    parameter int N_SLOTS = MAX_SLOTS,
    localparam int IDX_W  = $clog2(N_SLOTS),
    localparam int CNT_W  = $clog2(N_SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [N_SLOTS*2-1:0]     in_cls,
    input  logic [N_SLOTS*REG_W-1:0] in_dst,
    input  logic [N_SLOTS-1:0]       in_srca_int,
    input  logic [N_SLOTS*REG_W-1:0] in_srca,
    input  logic [N_SLOTS-1:0]       in_srcb_int,
    input  logic [N_SLOTS*REG_W-1:0] in_srcb,
    input  logic [N_SLOTS*IMM_W-1:0] in_imm,
    input  logic [N_SLOTS*BLK_W-1:0] in_blk,
    output logic [N_SLOTS*2-1:0]     out_cls,
    output logic [N_SLOTS*REG_W-1:0] out_dst,
    output logic [N_SLOTS-1:0]       out_srca_int,
    output logic [N_SLOTS*REG_W-1:0] out_srca,
    output logic [N_SLOTS-1:0]       out_srcb_int,
    output logic [N_SLOTS*REG_W-1:0] out_srcb,
    output logic [N_SLOTS*IMM_W-1:0] out_imm,
    output logic [N_SLOTS*BLK_W-1:0] out_blk,
    output logic [CNT_W-1:0]         fold_count,
    output logic                     busy,
    output logic                     done
);
    logic             load, step, fold, prod_ok;
    logic [IDX_W-1:0] cursor;
    slot_t            seg   [N_SLOTS];
    prod_view_t       views [N_SLOTS];
    slot_t            cur, nxt;
    prod_view_t       prod;

    reassoc_pass_ctrl #(.N_SLOTS(N_SLOTS)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .load(load), .step(step),
        .cursor(cursor), .busy(busy), .done(done)
    );

    reassoc_slot_pick #(.N_SLOTS(N_SLOTS)) u_pick (
        .seg(seg), .views(views), .cursor(cursor),
        .cur(cur), .prod(prod), .prod_ok(prod_ok)
    );

    reassoc_fold u_fold (
        .cur(cur), .prod(prod), .prod_ok(prod_ok), .nxt(nxt), .fold(fold)
    );

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        slot_t in_rec;

        assign in_rec = '{
            cls:      op_cls_e'(in_cls[g*2 +: 2]),
            dst:      in_dst[g*REG_W +: REG_W],
            srca_int: in_srca_int[g],
            srca:     in_srca[g*REG_W +: REG_W],
            srcb_int: in_srcb_int[g],
            srcb:     in_srcb[g*REG_W +: REG_W],
            imm:      in_imm[g*IMM_W +: IMM_W],
            blk:      in_blk[g*BLK_W +: BLK_W]
        };

        always_ff @(posedge clk) begin
            if (rst)
                seg[g] <= '0;
            else if (load)
                seg[g] <= in_rec;
            else if (step && cursor == IDX_W'(g))
                seg[g] <= nxt;
        end

        assign views[g] = '{
            cls:      seg[g].cls,
            srca_int: seg[g].srca_int,
            srca:     seg[g].srca,
            imm:      seg[g].imm,
            blk:      seg[g].blk
        };

        assign out_cls[g*2 +: 2]          = seg[g].cls;
        assign out_dst[g*REG_W +: REG_W]  = seg[g].dst;
        assign out_srca_int[g]            = seg[g].srca_int;
        assign out_srca[g*REG_W +: REG_W] = seg[g].srca;
        assign out_srcb_int[g]            = seg[g].srcb_int;
        assign out_srcb[g*REG_W +: REG_W] = seg[g].srcb;
        assign out_imm[g*IMM_W +: IMM_W]  = seg[g].imm;
        assign out_blk[g*BLK_W +: BLK_W]  = seg[g].blk;
    end

    always_ff @(posedge clk) begin
        if (rst)
            fold_count <= '0;
        else if (load)
            fold_count <= '0;
        else if (step && fold)
            fold_count <= fold_count + CNT_W'(1);
    end
endmodule

// File: rtl/reassoc_checker.sv
module reassoc_checker
    import trace_reassoc_pkg::*;
#(
    parameter int N_SLOTS = 16,
    localparam int CNT_W  = $clog2(N_SLOTS + 1)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     busy,
    input logic                     done,
    input logic [CNT_W-1:0]         fold_count,
    input logic [N_SLOTS*2-1:0]     out_cls,
    input logic [N_SLOTS*REG_W-1:0] out_dst,
    input logic [N_SLOTS-1:0]       out_srca_int,
    input logic [N_SLOTS*REG_W-1:0] out_srca,
    input logic [N_SLOTS-1:0]       out_srcb_int,
    input logic [N_SLOTS*REG_W-1:0] out_srcb,
    input logic [N_SLOTS*IMM_W-1:0] out_imm,
    input logic [N_SLOTS*BLK_W-1:0] out_blk
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && fold_count == '0));

    assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_done_at_end_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        !start |=> (fold_count == $past(fold_count) ||
                    fold_count == $past(fold_count) + CNT_W'(1)));

    assert_fixed_fields_R8: assert property (@(posedge clk) disable iff (rst)
        !(start && !busy) |=> ($stable(out_cls) && $stable(out_dst) &&
                               $stable(out_blk) && $stable(out_srcb) &&
                               $stable(out_srcb_int)));

    assert_hold_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(out_srca) && $stable(out_srca_int) &&
                               $stable(out_imm) && $stable(fold_count) &&
                               $stable(done)));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !$fell(busy)) |-> !done);
endmodule

bind trace_reassoc_unit reassoc_checker #(.N_SLOTS(N_SLOTS)) u_checker (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .fold_count(fold_count), .out_cls(out_cls), .out_dst(out_dst),
    .out_srca_int(out_srca_int), .out_srca(out_srca),
    .out_srcb_int(out_srcb_int), .out_srcb(out_srcb),
    .out_imm(out_imm), .out_blk(out_blk)
);

// File: tb/tb_trace_reassoc_unit.sv
module tb_trace_reassoc_unit;
    import trace_reassoc_pkg::*;

    localparam int N  = 16;
    localparam int CW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    always #10 clk = ~clk;

    logic [N*2-1:0]     in_cls, out_cls;
    logic [N*REG_W-1:0] in_dst, in_srca, in_srcb, out_dst, out_srca, out_srcb;
    logic [N-1:0]       in_srca_int, in_srcb_int, out_srca_int, out_srcb_int;
    logic [N*IMM_W-1:0] in_imm, out_imm;
    logic [N*BLK_W-1:0] in_blk, out_blk;
    logic [CW-1:0]      fold_count;
    logic               busy, done;

    // Stimulus arrays
    logic [1:0]  b_cls [N];
    logic [4:0]  b_dst [N], b_sa [N], b_sb [N];
    logic        b_sai [N], b_sbi [N];
    logic [15:0] b_imm [N];
    logic [1:0]  b_blk [N];
    // Expected arrays
    logic [1:0]  e_cls [N];
    logic [4:0]  e_dst [N], e_sa [N], e_sb [N];
    logic        e_sai [N], e_sbi [N];
    logic [15:0] e_imm [N];
    logic [1:0]  e_blk [N];
    int          e_cnt;

    int checks = 0;
    int errors = 0;

    for (genvar g = 0; g < N; g++) begin : g_drv
        assign in_cls[g*2 +: 2]          = b_cls[g];
        assign in_dst[g*REG_W +: REG_W]  = b_dst[g];
        assign in_srca_int[g]            = b_sai[g];
        assign in_srca[g*REG_W +: REG_W] = b_sa[g];
        assign in_srcb_int[g]            = b_sbi[g];
        assign in_srcb[g*REG_W +: REG_W] = b_sb[g];
        assign in_imm[g*IMM_W +: IMM_W]  = b_imm[g];
        assign in_blk[g*BLK_W +: BLK_W]  = b_blk[g];
    end

    trace_reassoc_unit #(.N_SLOTS(N)) dut (
        .clk(clk), .rst(rst), .start(start),
        .in_cls(in_cls), .in_dst(in_dst), .in_srca_int(in_srca_int), .in_srca(in_srca),
        .in_srcb_int(in_srcb_int), .in_srcb(in_srcb), .in_imm(in_imm), .in_blk(in_blk),
        .out_cls(out_cls), .out_dst(out_dst), .out_srca_int(out_srca_int), .out_srca(out_srca),
        .out_srcb_int(out_srcb_int), .out_srcb(out_srcb), .out_imm(out_imm), .out_blk(out_blk),
        .fold_count(fold_count), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Program-order reference: each slot sees earlier rewritten records
    task automatic model();
        e_cnt = 0;
        for (int i = 0; i < N; i++) begin
            e_cls[i] = b_cls[i]; e_dst[i] = b_dst[i]; e_sai[i] = b_sai[i];
            e_sa[i] = b_sa[i]; e_sbi[i] = b_sbi[i]; e_sb[i] = b_sb[i];
            e_imm[i] = b_imm[i]; e_blk[i] = b_blk[i];
        end
        for (int i = 0; i < N; i++) begin
            if (e_cls[i] == 2'd1 && e_sai[i] && int'(e_sa[i]) < i) begin
                int p;
                int s;
                p = int'(e_sa[i]);
                s = int'($signed(e_imm[p])) + int'($signed(e_imm[i]));
                if (e_cls[p] == 2'd1 && e_blk[p] != e_blk[i] &&
                    s >= -32768 && s <= 32767) begin
                    e_sai[i] = e_sai[p];
                    e_sa[i]  = e_sa[p];
                    e_imm[i] = 16'(s);
                    e_cnt++;
                end
            end
        end
    endtask

    task automatic compare_all(input string tag);
        for (int i = 0; i < N; i++) begin
            bit ok_fix, ok_rw;
            ok_fix = out_cls[i*2 +: 2] == e_cls[i] && out_dst[i*5 +: 5] == e_dst[i] &&
                     out_blk[i*2 +: 2] == e_blk[i] && out_srcb[i*5 +: 5] == e_sb[i] &&
                     out_srcb_int[i] == e_sbi[i];
            ok_rw  = out_srca_int[i] == e_sai[i] && out_srca[i*5 +: 5] == e_sa[i] &&
                     out_imm[i*16 +: 16] == e_imm[i];
            chk(ok_fix, {tag, " R8"}, $sformatf("slot %0d fixed fields", i),
                {out_cls[i*2 +: 2], out_dst[i*5 +: 5], out_blk[i*2 +: 2]},
                {e_cls[i], e_dst[i], e_blk[i]});
            chk(ok_rw, {tag, " R3"}, $sformatf("slot %0d {flag,srcA,imm}", i),
                {out_srca_int[i], out_srca[i*5 +: 5], out_imm[i*16 +: 16]},
                {e_sai[i], e_sa[i], e_imm[i]});
        end
        chk(fold_count == CW'(e_cnt), {tag, " R9"}, "fold_count", fold_count, e_cnt);
    endtask

    // Pulse start, then check the timing of busy/done. Optionally disturb mid-pass.
    task automatic run_pass(input bit disturb);
        model();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R2", "busy after capture", {busy, done}, 2'b10);
        for (int k = 1; k < N; k++) begin
            if (disturb && k == 5) begin
                for (int i = 0; i < N; i++) b_imm[i] = 16'($urandom);
                start = 1'b1;
            end
            @(negedge clk) start = 1'b0;
        end
        chk(done == 1'b0, disturb ? "R10" : "R2", "done one cycle early", done, 0);
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, disturb ? "R10" : "R2", "done at end",
            {busy, done}, 2'b01);
    endtask

    task automatic gen_random();
        int blk;
        blk = 0;
        for (int i = 0; i < N; i++) begin
            int r;
            r = int'($urandom % 8);
            b_cls[i] = (r < 5) ? 2'd1 : 2'(r - 4);
            if ($urandom % 3 == 0 && blk < 3) blk++;
            b_blk[i] = 2'(blk);
            b_dst[i] = 5'($urandom);
            b_sai[i] = (i > 0) && ($urandom % 4 != 0);
            b_sa[i]  = b_sai[i] ? 5'($urandom % i) : 5'($urandom);
            b_sbi[i] = 1'($urandom);
            b_sb[i]  = 5'($urandom);
            case ($urandom % 4)
                0: b_imm[i] = 16'($urandom % 16);
                1: b_imm[i] = 16'hFFF0 + 16'($urandom % 16);
                2: b_imm[i] = 16'h7FF0 + 16'($urandom % 16);
                default: b_imm[i] = 16'($urandom);
            endcase
        end
    endtask

    task automatic set_slot(input int i, input logic [1:0] c, input logic [4:0] d,
                            input logic sai, input logic [4:0] sa,
                            input logic [15:0] im, input logic [1:0] bk);
        b_cls[i] = c; b_dst[i] = d; b_sai[i] = sai; b_sa[i] = sa;
        b_sbi[i] = 1'b1; b_sb[i] = 5'd2; b_imm[i] = im; b_blk[i] = bk;
    endtask

    task automatic directed_seg();
        for (int i = 0; i < N; i++) set_slot(i, 2'd0, 5'(i), 1'b0, 5'd0, 16'd0, 2'd3);
        set_slot(0,  2'd1, 5'd1,  1'b0, 5'd2,  16'd4,    2'd0);
        set_slot(1,  2'd1, 5'd3,  1'b1, 5'd0,  16'd4,    2'd1);
        set_slot(2,  2'd1, 5'd4,  1'b1, 5'd1,  16'hFFFE, 2'd2);
        set_slot(3,  2'd1, 5'd5,  1'b1, 5'd2,  16'd5,    2'd2);
        set_slot(4,  2'd1, 5'd6,  1'b0, 5'd7,  16'h7FFF, 2'd2);
        set_slot(5,  2'd1, 5'd7,  1'b1, 5'd4,  16'd1,    2'd3);
        set_slot(6,  2'd3, 5'd8,  1'b0, 5'd9,  16'd3,    2'd2);
        set_slot(7,  2'd1, 5'd9,  1'b1, 5'd6,  16'd2,    2'd3);
        set_slot(8,  2'd1, 5'd10, 1'b1, 5'd3,  16'd1,    2'd3);
        set_slot(9,  2'd1, 5'd11, 1'b0, 5'd3,  16'd1,    2'd3);
        set_slot(10, 2'd1, 5'd12, 1'b1, 5'd10, 16'd1,    2'd3);
        set_slot(11, 2'd1, 5'd13, 1'b1, 5'd4,  16'h8000, 2'd3);
    endtask

    function automatic logic [21:0] rec(input int i);
        return {out_srca_int[i], out_srca[i*5 +: 5], out_imm[i*16 +: 16]};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7311));
        for (int i = 0; i < N; i++) set_slot(i, 2'd1, 5'd1, 1'b0, 5'd1, 16'd1, 2'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && fold_count == 0, "R1", "control after reset",
            {busy, done, fold_count}, 0);
        chk(out_imm == '0 && out_cls == '0 && out_srca == '0, "R1", "records after reset",
            out_imm[15:0], 0);

        // Directed segment
        directed_seg();
        run_pass(1'b0);
        compare_all("directed");
        chk(rec(1) == {1'b0, 5'd2, 16'd8}, "R3", "slot1 folds to live-in r2 +8", rec(1), {1'b0, 5'd2, 16'd8});
        chk(rec(2) == {1'b0, 5'd2, 16'd6}, "R7", "slot2 chain to r2 +6", rec(2), {1'b0, 5'd2, 16'd6});
        chk(rec(3) == {1'b1, 5'd2, 16'd5}, "R4", "slot3 same block kept", rec(3), {1'b1, 5'd2, 16'd5});
        chk(rec(5) == {1'b1, 5'd4, 16'd1}, "R5", "slot5 overflow kept", rec(5), {1'b1, 5'd4, 16'd1});
        chk(rec(7) == {1'b1, 5'd6, 16'd2}, "R6", "slot7 non-addi producer", rec(7), {1'b1, 5'd6, 16'd2});
        chk(rec(9) == {1'b0, 5'd3, 16'd1}, "R6", "slot9 live-in kept", rec(9), {1'b0, 5'd3, 16'd1});
        chk(rec(10) == {1'b1, 5'd10, 16'd1}, "R6", "slot10 forward index kept", rec(10), {1'b1, 5'd10, 16'd1});
        chk(rec(8) == {1'b1, 5'd2, 16'd6}, "R3", "slot8 inherits producer index", rec(8), {1'b1, 5'd2, 16'd6});
        chk(rec(11) == {1'b0, 5'd7, 16'hFFFF}, "R3", "slot11 mixed sign sum", rec(11), {1'b0, 5'd7, 16'hFFFF});
        chk(fold_count == 4, "R9", "directed fold count", fold_count, 4);

        // Start during a pass is ignored; results from the captured segment
        directed_seg();
        run_pass(1'b1);
        compare_all("restart-ignored R10");

        // Hold after done while inputs change
        gen_random();
        repeat (4) @(negedge clk);
        compare_all("hold R10");

        // Random segments
        for (int t = 0; t < 60; t++) begin
            gen_random();
            run_pass(1'b0);
            compare_all("random R5 R7");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule